// File: doc/BRIEF.md
# Event-to-Counter Mapping Unit

This unit keeps the association between a small set of hardware event identifiers and a bank of programmable performance counters, and turns a vector of raw event strobes into a per-counter increment vector. Software writes a 20-bit event index into the selector of one counter. The unit checks that the counter can be programmed and that the index names a supported event. It then either binds the event to that counter or leaves the table unchanged, and answers every write with a one-cycle acknowledge or error.

Each event is bound to at most one counter, and the first counter to claim an event keeps it. Several events may share one counter. Writing an index of zero to a counter releases every event bound to it. Counter slot 0 is hard-wired to the cycle event and slot 2 to the retired-instruction event. Slot 1 and every slot past the programmable range never increment. A combinational query port reports whether a chosen counter slot is tracking cycles or instructions. Overflow prediction logic placed next to the counters uses this result.

Top module: `event_route_unit`

## Requirements
- R1: After a synchronous active-low reset, no event is bound, `ctr_inc`, `sel_ack` and `sel_err` are zero, and the query reports cycles only for slot 0 and instructions only for slot 2.
- R2: An index has a 4-bit type in bits [19:16] and a 16-bit code in bits [15:0]. Type 1 (cache) codes hold a cache id in [15:3], an operation in [2:1] and a result in [0]. Only 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data-TLB read miss), 0x1001B (data-TLB write miss) and 0x10021 (instruction-TLB miss) are accepted. Any other non-zero index gets `sel_err` and leaves the table unchanged.
- R3: Only slots 3 to 3+NUM_PROG-1 (3..10 by default) are programmable. A write to any other slot gets `sel_err` and changes nothing.
- R4: Every selector write gets exactly one of `sel_ack` or `sel_err`, one cycle after the write, and neither is raised without a write.
- R5: A supported index that is not yet bound, written to a programmable slot, binds that event to the slot and is acknowledged.
- R6: A supported index that is already bound is acknowledged, but the existing binding is kept.
- R7: Writing zero to a programmable slot is acknowledged and unbinds every event bound to that slot, leaving other bindings intact.
- R8: Strobe bits are 0 cycles, 1 instructions, 2 data-TLB read miss, 3 data-TLB write miss, 4 instruction-TLB miss. A strobe in cycle N sets, in cycle N+1, the increment bit of the slot its event is bound to. Events sharing a slot are OR-ed together.
- R9: `ctr_inc[0]` follows the cycle strobe and `ctr_inc[2]` follows the instruction strobe one cycle later, whatever the bindings. `ctr_inc[1]` and the slots past the programmable range stay zero.
- R10: `qry_is_cycles` is high when `qry_ctr` is 0 or is the slot the cycle event is bound to. `qry_is_instr` is high when `qry_ctr` is 2 or is the slot the instruction event is bound to. Both are combinational from the current table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_ctr | input | $clog2(NUM_CTR) | Counter slot targeted by the write |
| sel_wr_idx | input | 20 | Event index written |
| sel_ack | output | 1 | Write accepted (one cycle after write) |
| sel_err | output | 1 | Write rejected (one cycle after write) |
| evt_strobe | input | 5 | Raw event strobes, one per supported event |
| ctr_inc | output | NUM_CTR | Registered per-slot increment vector |
| qry_ctr | input | $clog2(NUM_CTR) | Slot to query |
| qry_is_cycles | output | 1 | Queried slot tracks cycles |
| qry_is_instr | output | 1 | Queried slot tracks instructions |

## Verification
The write reply and the increment vector come from flops, so both are due one clock after the edge that captures the write or strobe. The query outputs settle in the same cycle as `qry_ctr` and reflect the table as updated by the last write edge. The bench drives every input on a falling edge and reads the reply or the increments on the next falling edge, one rising edge later. Queries are read a few time units after `qry_ctr` changes, while writes and strobes are held idle. A table model in the bench, updated only after each reply is checked, supplies the expected values.

// File: rtl/evr_pkg.sv
// Package: shared constants, index layout and supported-event table for
// the event-to-counter mapping unit.
// Assumes: exactly five supported events; slot order fixes strobe order.
package evr_pkg;

    localparam int IDX_W      = 20;
    localparam int EVT_N      = 5;
    localparam int FIRST_PROG = 3;
    localparam int CYC_FIXED  = 0;
    localparam int INS_FIXED  = 2;

    // Event slots; the number is also the strobe bit position.
    localparam int SLOT_CYC     = 0;
    localparam int SLOT_INS     = 1;
    localparam int SLOT_DTLB_RD = 2;
    localparam int SLOT_DTLB_WR = 3;
    localparam int SLOT_ITLB    = 4;

    localparam logic [3:0] KIND_GENERIC = 4'h0;
    localparam logic [3:0] KIND_CACHE   = 4'h1;

    typedef logic [IDX_W-1:0] evt_idx_t;

    // Layout of a cache-type index.
    typedef struct packed {
        logic [3:0]  kind;
        logic [12:0] cache_id;
        logic [1:0]  op;
        logic        res;
    } cache_idx_t;

    function automatic evt_idx_t mk_generic(input logic [15:0] code);
        return {KIND_GENERIC, code};
    endfunction

    function automatic evt_idx_t mk_cache(input logic [12:0] id,
                                          input logic [1:0]  op,
                                          input logic        res);
        cache_idx_t c;
        c.kind     = KIND_CACHE;
        c.cache_id = id;
        c.op       = op;
        c.res      = res;
        return evt_idx_t'(c);
    endfunction

    // Index accepted for each event slot.
    function automatic evt_idx_t slot_index(input int slot);
        evt_idx_t v;
        case (slot)
            SLOT_CYC:     v = mk_generic(16'h0001);
            SLOT_INS:     v = mk_generic(16'h0002);
            SLOT_DTLB_RD: v = mk_cache(13'd3, 2'd0, 1'b1);
            SLOT_DTLB_WR: v = mk_cache(13'd3, 2'd1, 1'b1);
            SLOT_ITLB:    v = mk_cache(13'd4, 2'd0, 1'b1);
            default:      v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/evr_idx_decode.sv
// Module: matches a written event index against the supported set.
// Assumes: at most one slot matches (supported indices are distinct).
module evr_idx_decode
    import evr_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [EVT_N-1:0] hit,
    output logic             known,
    output logic             is_zero
);

    // One comparator per supported event.
    for (genvar s = 0; s < EVT_N; s++) begin : g_cmp
        assign hit[s] = (idx == slot_index(s));
    end

    // Summary flags for the write control.
    assign known   = |hit;
    assign is_zero = (idx == '0);

endmodule

// File: rtl/evr_map_table.sv
// Module: event-to-slot binding table with write checking and reply.
// Each event owns one valid bit and one slot number; first binder wins,
// zero unbinds every event on the written slot.
// Assumes: FIRST_PROG + NUM_PROG <= NUM_CTR.
module evr_map_table
    import evr_pkg::*;
#(
    parameter int NUM_CTR  = 16,
    parameter int NUM_PROG = 8,
    parameter int CTR_W    = $clog2(NUM_CTR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CTR_W-1:0]            wr_ctr,
    input  logic [IDX_W-1:0]            wr_idx,
    output logic                        wr_ack,
    output logic                        wr_err,
    output logic [EVT_N-1:0]            map_vld,
    output logic [EVT_N-1:0][CTR_W-1:0] map_ctr
);

    localparam logic [CTR_W-1:0] PROG_LO = CTR_W'(FIRST_PROG);
    localparam logic [CTR_W-1:0] PROG_HI = CTR_W'(FIRST_PROG + NUM_PROG - 1);

    logic [EVT_N-1:0] hit;
    logic             known;
    logic             is_zero;
    logic             ctr_ok;
    logic             accept;

    evr_idx_decode u_dec (
        .idx     (wr_idx),
        .hit     (hit),
        .known   (known),
        .is_zero (is_zero)
    );

    // Target slot must lie in the programmable window.
    assign ctr_ok = (wr_ctr >= PROG_LO) && (wr_ctr <= PROG_HI);
    // A write is accepted when slot and index are both legal.
    assign accept = ctr_ok && (is_zero || known);

    // One storage entry per event.
    for (genvar s = 0; s < EVT_N; s++) begin : g_slot
        logic             vld_q;
        logic [CTR_W-1:0] ctr_q;
        logic             take;
        logic             drop;

        assign take = wr_en && ctr_ok && hit[s] && !vld_q;
        assign drop = wr_en && ctr_ok && is_zero && vld_q && (ctr_q == wr_ctr);

        // Bind on first claim, release on a zero write to the owner.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                ctr_q <= '0;
            end else if (take) begin
                vld_q <= 1'b1;
                ctr_q <= wr_ctr;
            end else if (drop) begin
                vld_q <= 1'b0;
            end
        end

        assign map_vld[s] = vld_q;
        assign map_ctr[s] = ctr_q;
    end

    // Registered reply: exactly one flag per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            wr_ack <= wr_en && accept;
            wr_err <= wr_en && !accept;
        end
    end

endmodule

// File: rtl/evr_inc_route.sv
// Module: turns event strobes into a registered per-slot increment vector.
// Fixed slots follow their own strobe; programmable slots OR the strobes
// of every event bound to them; other slots stay idle.
// Assumes: bound slot numbers are always inside the programmable window.
module evr_inc_route
    import evr_pkg::*;
#(
    parameter int NUM_CTR  = 16,
    parameter int NUM_PROG = 8,
    parameter int CTR_W    = $clog2(NUM_CTR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [EVT_N-1:0]            strobe,
    input  logic [EVT_N-1:0]            map_vld,
    input  logic [EVT_N-1:0][CTR_W-1:0] map_ctr,
    output logic [NUM_CTR-1:0]          inc
);

    logic [NUM_CTR-1:0] inc_d;

    for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
        if (c == CYC_FIXED) begin : g_cyc
            assign inc_d[c] = strobe[SLOT_CYC];
        end else if (c == INS_FIXED) begin : g_ins
            assign inc_d[c] = strobe[SLOT_INS];
        end else if (c >= FIRST_PROG && c < FIRST_PROG + NUM_PROG) begin : g_prog
            logic any_hit;
            // OR of every strobe whose event is bound here.
            always_comb begin
                any_hit = 1'b0;
                for (int s = 0; s < EVT_N; s++) begin
                    if (map_vld[s] && strobe[s] && (map_ctr[s] == CTR_W'(c))) begin
                        any_hit = 1'b1;
                    end
                end
            end
            assign inc_d[c] = any_hit;
        end else begin : g_idle
            assign inc_d[c] = 1'b0;
        end
    end

    // Pipeline register on the increment vector.
    always_ff @(posedge clk) begin
        if (!rst_n) inc <= '0;
        else        inc <= inc_d;
    end

endmodule

// File: rtl/evr_query.sv
// Module: combinational lookup of whether a slot counts cycles or
// retired instructions.
// Assumes: a bound slot is never a fixed slot.
module evr_query
    import evr_pkg::*;
#(
    parameter int NUM_CTR = 16,
    parameter int CTR_W   = $clog2(NUM_CTR)
) (
    input  logic [CTR_W-1:0]            qry,
    input  logic [EVT_N-1:0]            map_vld,
    input  logic [EVT_N-1:0][CTR_W-1:0] map_ctr,
    output logic                        is_cyc,
    output logic                        is_ins
);

    // Fixed slot or the current binding of the event.
    assign is_cyc = (qry == CTR_W'(CYC_FIXED)) ||
                    (map_vld[SLOT_CYC] && (map_ctr[SLOT_CYC] == qry));
    assign is_ins = (qry == CTR_W'(INS_FIXED)) ||
                    (map_vld[SLOT_INS] && (map_ctr[SLOT_INS] == qry));

endmodule

// File: rtl/event_route_unit.sv
// Module: top of the event-to-counter mapping unit.
// Assumes: synchronous active-low reset; 3 + NUM_PROG <= NUM_CTR.
module event_route_unit
    import evr_pkg::*;
#(
    parameter int NUM_CTR  = 16,
    parameter int NUM_PROG = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_wr_en,
    input  logic [$clog2(NUM_CTR)-1:0] sel_wr_ctr,
    input  logic [19:0]                sel_wr_idx,
    output logic                       sel_ack,
    output logic                       sel_err,
    input  logic [4:0]                 evt_strobe,
    output logic [NUM_CTR-1:0]         ctr_inc,
    input  logic [$clog2(NUM_CTR)-1:0] qry_ctr,
    output logic                       qry_is_cycles,
    output logic                       qry_is_instr
);

    localparam int CTR_W = $clog2(NUM_CTR);

    logic [EVT_N-1:0]            map_vld;
    logic [EVT_N-1:0][CTR_W-1:0] map_ctr;

    evr_map_table #(.NUM_CTR(NUM_CTR), .NUM_PROG(NUM_PROG), .CTR_W(CTR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr_en),
        .wr_ctr  (sel_wr_ctr),
        .wr_idx  (sel_wr_idx),
        .wr_ack  (sel_ack),
        .wr_err  (sel_err),
        .map_vld (map_vld),
        .map_ctr (map_ctr)
    );

    evr_inc_route #(.NUM_CTR(NUM_CTR), .NUM_PROG(NUM_PROG), .CTR_W(CTR_W)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (evt_strobe),
        .map_vld (map_vld),
        .map_ctr (map_ctr),
        .inc     (ctr_inc)
    );

    evr_query #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_query (
        .qry     (qry_ctr),
        .map_vld (map_vld),
        .map_ctr (map_ctr),
        .is_cyc  (qry_is_cycles),
        .is_ins  (qry_is_instr)
    );

endmodule

// File: rtl/evr_checker.sv
// Module: protocol and timing properties of event_route_unit, bound to it.
module evr_checker #(
    parameter int NUM_CTR  = 16,
    parameter int NUM_PROG = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sel_wr_en,
    input logic [$clog2(NUM_CTR)-1:0] sel_wr_ctr,
    input logic                       sel_ack,
    input logic                       sel_err,
    input logic [4:0]                 evt_strobe,
    input logic [NUM_CTR-1:0]         ctr_inc,
    input logic [$clog2(NUM_CTR)-1:0] qry_ctr,
    input logic                       qry_is_cycles,
    input logic                       qry_is_instr
);

    localparam int CTR_W = $clog2(NUM_CTR);
    localparam logic [CTR_W-1:0] HI = CTR_W'(3 + NUM_PROG - 1);

    assert_one_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ack && sel_err));

    assert_reply_due_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr_en |=> (sel_ack || sel_err));

    assert_no_stray_reply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ack || sel_err) |-> $past(sel_wr_en));

    assert_bad_slot_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_en && (sel_wr_ctr < CTR_W'(3) || sel_wr_ctr > HI)) |=> sel_err);

    assert_fixed_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctr_inc[0] == $past(evt_strobe[0])));

    assert_fixed_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctr_inc[2] == $past(evt_strobe[1])));

    assert_prog_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctr_inc[3 + NUM_PROG - 1:3]) |-> $past(|evt_strobe));

    assert_query_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((qry_ctr == CTR_W'(0)) |-> qry_is_cycles) and
        ((qry_ctr == CTR_W'(2)) |-> qry_is_instr));

endmodule

bind event_route_unit evr_checker #(.NUM_CTR(NUM_CTR), .NUM_PROG(NUM_PROG)) u_evr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_wr_en     (sel_wr_en),
    .sel_wr_ctr    (sel_wr_ctr),
    .sel_ack       (sel_ack),
    .sel_err       (sel_err),
    .evt_strobe    (evt_strobe),
    .ctr_inc       (ctr_inc),
    .qry_ctr       (qry_ctr),
    .qry_is_cycles (qry_is_cycles),
    .qry_is_instr  (qry_is_instr)
);

// File: tb/tb_event_route_unit.sv
module tb_event_route_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 16;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_wr_en = 1'b0;
    logic [3:0]    sel_wr_ctr = '0;
    logic [19:0]   sel_wr_idx = '0;
    logic          sel_ack;
    logic          sel_err;
    logic [4:0]    evt_strobe = '0;
    logic [NC-1:0] ctr_inc;
    logic [3:0]    qry_ctr = '0;
    logic          qry_is_cycles;
    logic          qry_is_instr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model of the binding table.
    bit mv [5];
    int mc [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    event_route_unit #(.NUM_CTR(NC), .NUM_PROG(NP)) dut (
        .clk(clk), .rst_n(rst_n),
        .sel_wr_en(sel_wr_en), .sel_wr_ctr(sel_wr_ctr), .sel_wr_idx(sel_wr_idx),
        .sel_ack(sel_ack), .sel_err(sel_err),
        .evt_strobe(evt_strobe), .ctr_inc(ctr_inc),
        .qry_ctr(qry_ctr), .qry_is_cycles(qry_is_cycles), .qry_is_instr(qry_is_instr)
    );

    function automatic logic [19:0] idx_of(input int s);
        case (s)
            0: return 20'h00001;
            1: return 20'h00002;
            2: return 20'h10019;
            3: return 20'h1001B;
            default: return 20'h10021;
        endcase
    endfunction

    function automatic int slot_of(input logic [19:0] d);
        for (int s = 0; s < 5; s++) if (d == idx_of(s)) return s;
        return -1;
    endfunction

    function automatic bit slot_prog(input int c);
        return (c >= 3) && (c < 3 + NP);
    endfunction

    function automatic logic [NC-1:0] exp_inc(input logic [4:0] s);
        logic [NC-1:0] v = '0;
        v[0] = s[0];
        v[2] = s[1];
        for (int e = 0; e < 5; e++) if (mv[e] && s[e]) v[mc[e]] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Selector write; reply checked one edge later, model updated after.
    task automatic wr(input int c, input logic [19:0] d);
        int s;
        string tag;
        logic [1:0] exp;
        s = slot_of(d);
        if (!slot_prog(c))      begin tag = "R3"; exp = 2'b01; end
        else if (d == '0)       begin tag = "R7"; exp = 2'b10; end
        else if (s < 0)         begin tag = "R2"; exp = 2'b01; end
        else if (mv[s])         begin tag = "R6"; exp = 2'b10; end
        else                    begin tag = "R5"; exp = 2'b10; end
        @(negedge clk);
        sel_wr_en = 1'b1; sel_wr_ctr = 4'(c); sel_wr_idx = d;
        @(negedge clk);
        sel_wr_en = 1'b0;
        check({sel_ack, sel_err} == exp, {tag, " R4 reply"}, 32'({sel_ack, sel_err}), 32'(exp));
        if (tag == "R7") begin
            for (int e = 0; e < 5; e++) if (mv[e] && mc[e] == c) mv[e] = 1'b0;
        end else if (tag == "R5") begin
            mv[s] = 1'b1; mc[s] = c;
        end
    endtask

    // Strobe pattern; increments due one edge later.
    task automatic strobe(input logic [4:0] s, input string req);
        logic [NC-1:0] exp;
        exp = exp_inc(s);
        @(negedge clk);
        evt_strobe = s;
        @(negedge clk);
        evt_strobe = '0;
        check(ctr_inc == exp, req, 32'(ctr_inc), 32'(exp));
    endtask

    // Query sweep over every slot while inputs stay idle.
    task automatic query_all();
        for (int c = 0; c < NC; c++) begin
            bit ec, ei;
            ec = (c == 0) || (mv[0] && mc[0] == c);
            ei = (c == 2) || (mv[1] && mc[1] == c);
            qry_ctr = 4'(c);
            #1;
            check({qry_is_cycles, qry_is_instr} == {ec, ei}, "R10 query",
                  32'({qry_is_cycles, qry_is_instr}), 32'({ec, ei}));
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2417);
        for (int e = 0; e < 5; e++) begin mv[e] = 1'b0; mc[e] = 0; end
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ctr_inc == '0, "R1 inc", 32'(ctr_inc), 0);
        check(!sel_ack && !sel_err, "R1 reply", 32'({sel_ack, sel_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        query_all();
        strobe(5'b11111, "R1 R9 no bindings");

        // Directed corner cases
        wr(3, 20'h00001);
        strobe(5'b00001, "R5 R8 cycles on slot 3");
        wr(4, 20'h00001);
        strobe(5'b00001, "R6 first binder kept");
        wr(5, 20'h10019);
        wr(5, 20'h1001B);
        strobe(5'b01000, "R8 shared slot write miss");
        strobe(5'b00100, "R8 shared slot read miss");
        query_all();
        wr(5, 20'h0);
        strobe(5'b01101, "R7 slot 5 released");
        wr(2, 20'h10021);
        wr(1, 20'h00002);
        wr(11, 20'h10021);
        wr(15, 20'h0);
        strobe(5'b10000, "R3 no binding from bad slot");
        wr(6, 20'h10018);
        wr(6, 20'h20001);
        wr(6, 20'h00003);
        wr(6, 20'h1001A);
        strobe(5'b11111, "R2 rejected indices");
        wr(10, 20'h10021);
        wr(7, 20'h00002);
        strobe(5'b10010, "R8 R9 top slot and instr");
        query_all();
        strobe(5'b00011, "R9 fixed slots");

        // Constrained random phase
        for (int i = 0; i < 400; i++) begin
            int k;
            int c;
            logic [19:0] d;
            k = int'($urandom % 8);
            c = int'($urandom % 16);
            if (k < 5)       d = idx_of(k);
            else if (k == 5) d = 20'h0;
            else if (k == 6) d = 20'($urandom);
            else             d = idx_of(int'($urandom % 5)) ^ (20'h1 << ($urandom % 20));
            wr(c, d);
            strobe(5'($urandom), "R8 random strobe");
            if (i % 25 == 0) query_all();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule